// File: doc/BRIEF.md
# Random Word Output Buffer and Register Front End

This block is the bus-facing side of a true random generator. A conditioning stage, outside this block, produces one 128-bit result per round and signals it with a done strobe. The block latches that result in a staging register, moves it as four 32-bit words into an output buffer once the buffer has been drained, and then requests the next round. Software sees three word registers: control at offset 0x0, status at 0x4 and data at 0x8. Each read of the data register takes one word out of the buffer.

Reading the data register while nothing is ready returns zero. The buffer, the staging register and the data-ready flag keep working while the generator enable is off. Only the start of new rounds and the interrupt output depend on the enable. A seed error from the health tests empties the buffer and the staging register. A clock error only raises flags. One interrupt line combines data ready and the two sticky error flags. Any access that is not an aligned 32-bit word access is answered with a bus error and has no effect.

Top module: `rng_obuf_regs`

## Requirements
- R1: The control register resets to 0. Its fields are generator enable at bit 2, interrupt enable at bit 3 and clock-check disable at bit 5. All other bits of the control and status registers read as 0 and ignore writes.
- R2: The status register reads as: data ready at bit 0, clock error current at bit 1, seed error current at bit 2, clock error sticky at bit 5 and seed error sticky at bit 6. It reads 0 after reset.
- R3: A 128-bit conditioning result is loaded into the four-word buffer when the buffer is empty. The word in bits 31:0 is read first and the word in bits 127:96 is read last. A new round is requested with a one-cycle start pulse only when three conditions hold: the staging register is empty, no round is in flight and the generator is enabled.
- R4: Data ready is 1 when the buffer holds a word or the staging register holds a result. It stays 1 until both are used up.
- R5: A data register read while data ready is 0 returns zero and changes nothing.
- R6: An access whose size code is not 2'b10 (word), or whose address bits 1:0 are not 0, asserts the error output for that cycle, reads as zero, does not consume a word, and a write of that kind changes no register.
- R7: The interrupt output equals generator enable AND interrupt enable AND (data ready OR clock sticky OR seed sticky).
- R8: While the generator is disabled, buffered words remain readable in order, a round already in flight is still captured and can raise data ready, and no new round is requested.
- R9: With clock-check disable at 0, the clock error input sets the clock current bit and the clock sticky bit one cycle later. The current bit follows the input and the sticky bit stays set. With clock-check disable at 1, the input is ignored.
- R10: Writing 0 to status bit 5 or bit 6 clears that sticky flag. Writing 1 leaves it unchanged. A pending error takes precedence over the clear.
- R11: While the seed error input is 1, the seed current bit and the seed sticky bit are set. The buffer and the staging register are emptied, so data ready and data reads are 0, and no round is requested. Generation resumes when the input returns to 0.
- R12: A write to the clock-check disable bit takes effect only when generator enable is 0 before the write.
- R13: Reading the data register when the buffer is empty but the staging register is full returns the low word of the staging register. The remaining three words are then read in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, single cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | Access size code, 2'b10 = 32-bit word |
| wdata_i | input | WORD_W | Write data |
| rdata_o | output | WORD_W | Read data, same cycle as the request |
| err_o | output | 1 | Bus error response, same cycle as the request |
| irq_o | output | 1 | Combined interrupt |
| gen_en_o | output | 1 | Generator enable to the noise source |
| cond_start_o | output | 1 | Start pulse for one conditioning round |
| cond_done_i | input | 1 | Conditioning round finished |
| cond_data_i | input | WORD_W*DEPTH | Conditioning result |
| seed_err_i | input | 1 | Seed health-test failure, current |
| clk_err_i | input | 1 | Sampling clock too slow, current |

## Verification
The bench first exercises word delivery with reads spaced apart. It then drains eight words back to back, which goes through the path where the buffer is empty and the word is served straight from the staging register. A mismatch in word order or a dropped word between those two paths shows up in the comparison. Reads are also issued with the generator disabled, with a round still in flight, after malformed accesses and after a seed-error flush. These tell apart an enable that wrongly gates the buffer, an error access that wrongly consumes a word, and a flush that wrongly leaves stale data. The error inputs are toggled with clock checking both on and off, and with clearing writes of both polarities, to separate current flags from sticky flags.

// File: rtl/rng_obuf_pkg.sv
package rng_obuf_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_DATA = 8;

  localparam int unsigned CB_EN    = 2;
  localparam int unsigned CB_IE    = 3;
  localparam int unsigned CB_CKDIS = 5;

  localparam int unsigned SB_RDY   = 0;
  localparam int unsigned SB_CKCUR = 1;
  localparam int unsigned SB_SDCUR = 2;
  localparam int unsigned SB_CKSTK = 5;
  localparam int unsigned SB_SDSTK = 6;

  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef struct packed {
    logic ckdis;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/rng_obuf_csr.sv
module rng_obuf_csr
  import rng_obuf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_ctrl_i,
  input  logic  wr_stat_i,
  input  ctrl_t wctrl_i,
  input  logic  wclr_ck_n_i,
  input  logic  wclr_sd_n_i,
  input  logic  seed_err_i,
  input  logic  clk_err_i,
  output ctrl_t ctrl_o,
  output logic  seed_cur_o,
  output logic  clk_cur_o,
  output logic  seed_stk_o,
  output logic  clk_stk_o
);
  logic ck_hit;
  assign ck_hit = clk_err_i && !ctrl_o.ckdis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (wr_ctrl_i) begin
      ctrl_o.en <= wctrl_i.en;
      ctrl_o.ie <= wctrl_i.ie;
      // clock-check mode is frozen while running
      if (!ctrl_o.en) ctrl_o.ckdis <= wctrl_i.ckdis;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_cur_o <= 1'b0;
      clk_cur_o  <= 1'b0;
      seed_stk_o <= 1'b0;
      clk_stk_o  <= 1'b0;
    end else begin
      seed_cur_o <= seed_err_i;
      clk_cur_o  <= ck_hit;
      if (seed_err_i)                   seed_stk_o <= 1'b1;
      else if (wr_stat_i && !wclr_sd_n_i) seed_stk_o <= 1'b0;
      if (ck_hit)                       clk_stk_o <= 1'b1;
      else if (wr_stat_i && !wclr_ck_n_i) clk_stk_o <= 1'b0;
    end
  end

  p_ckdis_locked_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && ctrl_o.en) |=> $stable(ctrl_o.ckdis));
  p_seed_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_cur_o |-> seed_stk_o);
  p_clk_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_cur_o |-> clk_stk_o);
endmodule

// File: rtl/rng_obuf_fifo.sv
module rng_obuf_fifo #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    flush_i,
  input  logic                    pop_i,
  input  logic                    cond_done_i,
  input  logic [WORD_W*DEPTH-1:0] cond_data_i,
  output logic [WORD_W-1:0]       head_o,
  output logic                    rdy_o,
  output logic                    cond_start_o
);
  localparam int unsigned STAGE_W = WORD_W * DEPTH;
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]   rd_ptr;
  logic [CNT_W-1:0]   cnt;
  logic [STAGE_W-1:0] stage;
  logic               stage_vld, busy;
  logic               buf_empty, xfer;

  assign buf_empty    = (cnt == '0);
  assign xfer         = buf_empty && stage_vld && !flush_i;
  assign rdy_o        = (!buf_empty || stage_vld) && !flush_i;
  assign cond_start_o = en_i && !stage_vld && !busy && !flush_i;

  always_comb begin
    head_o = '0;
    if (rdy_o) head_o = buf_empty ? stage[WORD_W-1:0] : mem[rd_ptr];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt       <= '0;
      rd_ptr    <= '0;
      stage     <= '0;
      stage_vld <= 1'b0;
      busy      <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (flush_i) begin
      cnt       <= '0;
      rd_ptr    <= '0;
      stage_vld <= 1'b0;
      busy      <= 1'b0;
    end else begin
      if (cond_start_o) busy <= 1'b1;
      if (cond_done_i && busy) begin
        busy      <= 1'b0;
        stage     <= cond_data_i;
        stage_vld <= 1'b1;
      end
      if (xfer) begin
        stage_vld <= 1'b0;
        for (int i = 0; i < DEPTH; i++) mem[i] <= stage[i*WORD_W +: WORD_W];
        // a read in the transfer cycle already took word 0
        rd_ptr <= pop_i ? PTR_W'(1) : '0;
        cnt    <= pop_i ? CNT_W'(DEPTH - 1) : CNT_W'(DEPTH);
      end else if (pop_i && !buf_empty) begin
        rd_ptr <= rd_ptr + 1'b1;
        cnt    <= cnt - 1'b1;
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));
  p_single_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_start_o |=> !cond_start_o);
  p_flush_empties_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt == '0) && !stage_vld);
  p_fill_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && !pop_i) |=> (cnt == CNT_W'(DEPTH)));
endmodule

// File: rtl/rng_obuf_regs.sv
module rng_obuf_regs
  import rng_obuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              size_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [WORD_W-1:0]       rdata_o,
  output logic                    err_o,
  output logic                    irq_o,
  output logic                    gen_en_o,
  output logic                    cond_start_o,
  input  logic                    cond_done_i,
  input  logic [WORD_W*DEPTH-1:0] cond_data_i,
  input  logic                    seed_err_i,
  input  logic                    clk_err_i
);
  ctrl_t             ctrl, wctrl;
  logic              acc_ok, sel_ctrl, sel_stat, sel_data;
  logic              wr_ctrl, wr_stat, pop;
  logic              seed_cur, clk_cur, seed_stk, clk_stk, rdy;
  logic [WORD_W-1:0] head;
  logic              unused_wdata;

  assign acc_ok   = req_i && (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00);
  assign err_o    = req_i && !acc_ok;
  assign sel_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_stat = (addr_i == ADDR_W'(OFS_STAT));
  assign sel_data = (addr_i == ADDR_W'(OFS_DATA));
  assign wr_ctrl  = acc_ok && we_i && sel_ctrl;
  assign wr_stat  = acc_ok && we_i && sel_stat;
  assign pop      = acc_ok && !we_i && sel_data && rdy;

  assign wctrl.en    = wdata_i[CB_EN];
  assign wctrl.ie    = wdata_i[CB_IE];
  assign wctrl.ckdis = wdata_i[CB_CKDIS];
  assign unused_wdata = ^wdata_i;

  rng_obuf_csr u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_ctrl),
    .wr_stat_i  (wr_stat),
    .wctrl_i    (wctrl),
    .wclr_ck_n_i(wdata_i[SB_CKSTK]),
    .wclr_sd_n_i(wdata_i[SB_SDSTK]),
    .seed_err_i (seed_err_i),
    .clk_err_i  (clk_err_i),
    .ctrl_o     (ctrl),
    .seed_cur_o (seed_cur),
    .clk_cur_o  (clk_cur),
    .seed_stk_o (seed_stk),
    .clk_stk_o  (clk_stk)
  );

  rng_obuf_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl.en),
    .flush_i     (seed_cur),
    .pop_i       (pop),
    .cond_done_i (cond_done_i),
    .cond_data_i (cond_data_i),
    .head_o      (head),
    .rdy_o       (rdy),
    .cond_start_o(cond_start_o)
  );

  always_comb begin
    rdata_o = '0;
    if (acc_ok && !we_i) begin
      if (sel_ctrl) begin
        rdata_o[CB_EN]    = ctrl.en;
        rdata_o[CB_IE]    = ctrl.ie;
        rdata_o[CB_CKDIS] = ctrl.ckdis;
      end else if (sel_stat) begin
        rdata_o[SB_RDY]   = rdy;
        rdata_o[SB_CKCUR] = clk_cur;
        rdata_o[SB_SDCUR] = seed_cur;
        rdata_o[SB_CKSTK] = clk_stk;
        rdata_o[SB_SDSTK] = seed_stk;
      end else if (sel_data) begin
        rdata_o = head;
      end
    end
  end

  assign gen_en_o = ctrl.en;
  assign irq_o    = ctrl.en && ctrl.ie && (rdy || seed_stk || clk_stk);

  p_empty_reads_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && !we_i && sel_data && !rdy) |-> (rdata_o == '0));
  p_bad_write_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && we_i) |=> $stable(ctrl));
  p_seed_blocks_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_cur |-> !cond_start_o && !rdy);
endmodule

// File: tb/rng_obuf_regs_tb.sv
`timescale 1ns/100ps
module rng_obuf_regs_tb;
  localparam int LAT = 213;
  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_DATA = 4'h8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [1:0] size = 2'b10;
  logic [31:0] wdata = '0, rdata;
  logic err, irq, gen_en, cond_start, cond_done = 1'b0;
  logic [127:0] cond_data = '0;
  logic seed_err = 1'b0, clk_err = 1'b0;

  int checks = 0, fails = 0, starts = 0, rounds = 0;
  bit stub_busy = 1'b0;
  logic [31:0] exp_q[$], obs_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rng_obuf_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .irq_o(irq),
    .gen_en_o(gen_en), .cond_start_o(cond_start), .cond_done_i(cond_done),
    .cond_data_i(cond_data), .seed_err_i(seed_err), .clk_err_i(clk_err)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // conditioning stub: driver side pushes the expected words
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && cond_start) begin
        starts++;
        stub_busy = 1'b1;
        repeat (LAT) @(negedge clk);
        rounds++;
        for (int i = 0; i < 4; i++) begin
          cond_data[i*32 +: 32] = 32'h5A00_0000 | (rounds << 4) | i;
          exp_q.push_back(32'h5A00_0000 | (rounds << 4) | i);
        end
        cond_done = 1'b1;
        @(negedge clk);
        cond_done = 1'b0;
        stub_busy = 1'b0;
      end
    end
  end

  // monitor: compares observed data words against the scoreboard
  initial begin
    forever begin
      logic [31:0] o;
      string t;
      wait (obs_q.size() != 0);
      o = obs_q.pop_front();
      t = tag_q.pop_front();
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL %s actual=%h expected=<none>", t, o);
      end else chk(t, o, exp_q.pop_front());
    end
  end

  task automatic bus(input logic w, input logic [3:0] a, input logic [1:0] sz,
                     input logic [31:0] d, output logic [31:0] r, output logic e);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    #1;
    r = rdata; e = err;
    @(posedge clk);
    #0.5;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    bus(1'b1, a, 2'b10, d, r, e);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] r);
    logic e;
    bus(1'b0, a, 2'b10, '0, r, e);
  endtask

  task automatic rd_word(input string t);
    logic [31:0] r;
    rd(A_DATA, r);
    obs_q.push_back(r);
    tag_q.push_back(t);
  endtask

  task automatic wait_rdy();
    logic [31:0] r;
    for (int i = 0; i < 2000; i++) begin
      rd(A_STAT, r);
      if (r[0]) break;
    end
  endtask

  task automatic wait_q(input int n);
    for (int i = 0; i < 2000; i++) begin
      if (exp_q.size() == n && !stub_busy) break;
      @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic e;
    int s0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state
    rd(A_CTRL, r); chk("R1 ctrl reset", r, 32'h0);
    rd(A_STAT, r); chk("R2 stat reset", r, 32'h0);
    bus(1'b0, A_DATA, 2'b10, '0, r, e);
    chk("R5 empty data read", r, 32'h0);
    chk("R6 no error on good read", {31'h0, e}, 32'h0);
    chk("R7 irq after reset", {31'h0, irq}, 32'h0);
    repeat (20) @(posedge clk);
    chk("R3 no round while disabled", starts, 0);

    // reserved bits
    wr(A_CTRL, 32'hFFFF_FFD3);
    rd(A_CTRL, r); chk("R1 reserved bits", r, 32'h0);
    wr(A_CTRL, 32'h0000_000C);
    rd(A_CTRL, r); chk("R1 enable and ie", r, 32'h0000_000C);

    // first data, two rounds fill buffer and staging
    wait_rdy();
    #1 chk("R7 irq on data ready", {31'h0, irq}, 32'h1);
    wait_q(8);
    chk("R3 two rounds started", starts, 3 - 1);
    for (int i = 0; i < 4; i++) rd_word("R3 buffered word");
    for (int i = 0; i < 4; i++) rd_word("R13 staged word back to back");
    rd(A_STAT, r); chk("R4 ready low once drained", r, 32'h0);
    rd(A_DATA, r); chk("R5 drained data read", r, 32'h0);

    // disabled operation
    wr(A_CTRL, 32'h0000_0008);
    wait_q(4);
    rd(A_STAT, r); chk("R8 ready rises while disabled", r, 32'h1);
    #1 chk("R7 irq gated by enable", {31'h0, irq}, 32'h0);
    repeat (20) @(posedge clk);
    chk("R8 no new round while disabled", starts, 3);

    // malformed accesses
    bus(1'b0, A_DATA, 2'b00, '0, r, e);
    chk("R6 byte read error", {31'h0, e}, 32'h1);
    chk("R6 byte read data", r, 32'h0);
    bus(1'b1, A_CTRL, 2'b01, 32'h4, r, e);
    chk("R6 halfword write error", {31'h0, e}, 32'h1);
    rd(A_CTRL, r); chk("R6 bad write ignored", r, 32'h0000_0008);
    bus(1'b0, 4'h9, 2'b10, '0, r, e);
    chk("R6 misaligned error", {31'h0, e}, 32'h1);
    for (int i = 0; i < 4; i++) rd_word("R8 read while disabled after R6 errors");
    rd(A_STAT, r); chk("R4 empty after four reads", r, 32'h0);

    // clock error flags
    clk_err = 1'b1;
    repeat (3) @(posedge clk);
    rd(A_STAT, r); chk("R9 clock flags set", r, 32'h22);
    #1 chk("R7 irq off while disabled", {31'h0, irq}, 32'h0);
    wr(A_CTRL, 32'h0000_000C);
    #1 chk("R7 irq from clock sticky", {31'h0, irq}, 32'h1);
    clk_err = 1'b0;
    repeat (3) @(posedge clk);
    rd(A_STAT, r); chk("R9 sticky stays", r, 32'h20);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, r); chk("R10 write one no effect", r, 32'h20);
    wr(A_STAT, 32'h0);
    rd(A_STAT, r); chk("R10 write zero clears", r, 32'h0);

    // clock-check mode lock
    wr(A_CTRL, 32'h0000_002C);
    rd(A_CTRL, r); chk("R12 mode locked while enabled", r, 32'h0000_000C);
    wr(A_CTRL, 32'h0000_0008);
    wr(A_CTRL, 32'h0000_0028);
    rd(A_CTRL, r); chk("R12 mode set while disabled", r, 32'h0000_0028);
    clk_err = 1'b1;
    repeat (3) @(posedge clk);
    rd(A_STAT, r); chk("R9 masked when check disabled", r & 32'hFFFF_FFFE, 32'h0);
    clk_err = 1'b0;
    wr(A_CTRL, 32'h0000_000C);

    // seed error flush
    wait_q(8);
    seed_err = 1'b1;
    repeat (3) @(posedge clk);
    rd(A_STAT, r); chk("R11 seed flags and flush", r, 32'h44);
    rd(A_DATA, r); chk("R11 data zero during seed error", r, 32'h0);
    s0 = starts;
    repeat (20) @(posedge clk);
    chk("R11 no round during seed error", starts, s0);
    exp_q.delete();
    seed_err = 1'b0;
    wr(A_STAT, 32'h0);
    rd(A_STAT, r); chk("R11 recovered status", r, 32'h0);
    wait_rdy();
    for (int i = 0; i < 4; i++) rd_word("R11 fresh words after recovery");

    repeat (5) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule